// File: doc/BRIEF.md
# Input Capture and Timer Event Flag Unit

This block timestamps edges on a set of capture pins and collects timer events into a flag register. Each capture pin first passes through a synchronizer. A two-bit edge-select code for each pin chooses which transitions count: none, rising, falling, or both. When a chosen transition is seen, the block copies the value of an external free-running counter into that channel's capture register and raises the channel's flag.

Output-compare events come from elsewhere as single-cycle strobes and land in the same flag register. Each flag has a mask bit at the same position. A single registered interrupt line is high while any flag is set together with its mask bit.

Software reaches the edge-select, mask, flag and capture registers over a simple synchronous bus. Writes take effect at the clock edge and reads are combinational. A flag is cleared by writing one to its position. Because of this, writing back a value that was read from the flag register clears every flag that read as set.

Top module: `tcap_unit`

## Requirements
- R1: After reset the edge-select, mask and flag registers read 0x00, all capture registers read 0x0000 and `irq` is low.
- R2: Address map: 0 is edge select, 1 is mask, 2 is flags, and 4+2c / 5+2c are the high / low bytes of capture channel c (c = 0..2). In the edge-select register, channel 0 sits in bits 5:4, channel 1 in bits 3:2 and channel 2 in bits 1:0. Bits 7:6 always read 0, and the mask register reads back what was written.
- R3: Edge code 00 disables a channel: pin transitions set no flag and leave its capture register unchanged.
- R4: Edge code 01 captures on rising transitions only.
- R5: Edge code 10 captures on falling transitions only.
- R6: Edge code 11 captures on both rising and falling transitions.
- R7: Suppose a pin level is presented before rising clock edge k. A selected transition is then visible in the flag and capture registers after edge k+2, and the capture register holds the counter value applied just before edge k+2.
- R8: Flag and mask layout: output-compare strobe bit j (j = 0..4) maps to bit 7-j, and capture channel c maps to bit 2-c. A strobe sets its flag at the next clock edge.
- R9: A flag is set by its event whether or not the matching mask bit is set.
- R10: Writing the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R11: If an event and a clearing write hit the same flag in the same cycle, the flag stays 1.
- R12: `irq` is a register. After each clock edge it equals the OR over the eight flag-AND-mask pairs as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_cnt | input | 16 | Free-running counter value to timestamp |
| ic_pin | input | 3 | Capture pins, bit c is channel c (asynchronous) |
| oc_evt | input | 5 | Output-compare event strobes, one cycle each |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held at time zero and that capture pins stay low through reset, so the synchronizer starts in agreement with the pin. The stimulus meets this by releasing reset only with all pins at 0. After that it changes one pin at a time, and only after the previous transition has fully settled. The free-running counter is held steady from each pin change until the capture is read back, so the expected timestamp is unambiguous. Output-compare strobes are always single-cycle pulses, as the flag logic assumes.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   localparam int unsigned ADR_EDGE = 0;
   localparam int unsigned ADR_MASK = 1;
   localparam int unsigned ADR_FLAG = 2;
   localparam int unsigned ADR_CAP0 = 4;

endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det
   import tcap_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      hit
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcap_edge_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl  = sync_q[SYNC_STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_OFF:  hit = 1'b0;
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_ANY:  hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_OFF) |-> !hit); // R3
   AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_RISE && hit) |-> (lvl && !prev_q)); // R4
   AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_FALL && hit) |-> (!lvl && prev_q)); // R5

endmodule

// File: rtl/tcap_cap_reg.sv
module tcap_cap_reg #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] q
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("tcap_cap_reg: CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= cnt;
   end

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R7

endmodule

// File: rtl/tcap_flag_bank.sv
module tcap_flag_bank #(
   parameter int N_OC  = 5,
   parameter int N_IC  = 3,
   parameter int REG_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic             flag_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [N_OC-1:0]  oc_evt,
   input  logic [N_IC-1:0]  ic_hit,
   output logic [REG_W-1:0] flag_q,
   output logic [REG_W-1:0] mask_q,
   output logic             irq
);

   generate
      if (N_OC + N_IC != REG_W) begin : g_bad_layout
         $error("tcap_flag_bank: N_OC + N_IC must equal REG_W");
      end
   endgenerate

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;

   generate
      for (genvar j = 0; j < N_OC; j++) begin : g_oc_map
         assign set_vec[REG_W-1-j] = oc_evt[j];
      end
      for (genvar c = 0; c < N_IC; c++) begin : g_ic_map
         assign set_vec[N_IC-1-c] = ic_hit[c];
      end
   endgenerate

   assign clr_vec = flag_wr ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         mask_q <= '0;
         irq    <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~clr_vec) | set_vec;
         if (mask_wr) mask_q <= wdata;
         irq <= |(flag_q & mask_q);
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec))); // R11
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0)); // R9
   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> ((flag_q & $past(flag_q) & ~$past(wdata)) == ($past(flag_q) & ~$past(wdata)))); // R10
   AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> ((flag_q & $past(wdata) & ~$past(set_vec)) == '0)); // R10
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((flag_q & mask_q) != '0)); // R12
   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past((flag_q & mask_q) == '0)); // R12

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
   import tcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_IC        = 3,
   parameter int N_OC        = 5,
   parameter int REG_W       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  free_cnt,
   input  logic [N_IC-1:0]   ic_pin,
   input  logic [N_OC-1:0]   oc_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              irq
);

   localparam int EDGE_W = 2 * N_IC;

   generate
      if (CNT_W != 2 * REG_W) begin : g_bad_cnt
         $error("tcap_unit: CNT_W must be twice REG_W");
      end
      if (EDGE_W > REG_W) begin : g_bad_edge
         $error("tcap_unit: edge fields do not fit the register");
      end
      if (ADR_CAP0 + 2 * N_IC > (1 << ADDR_W)) begin : g_bad_addr
         $error("tcap_unit: address space too small for capture registers");
      end
   endgenerate

   logic [EDGE_W-1:0] edge_q;
   logic [N_IC-1:0]   ic_hit;
   logic [CNT_W-1:0]  cap_q [N_IC];
   logic [REG_W-1:0]  flag_q;
   logic [REG_W-1:0]  mask_q;
   logic              wr_edge;
   logic              wr_mask;
   logic              wr_flag;

   assign wr_edge = bus_wr && (bus_addr == ADDR_W'(ADR_EDGE));
   assign wr_mask = bus_wr && (bus_addr == ADDR_W'(ADR_MASK));
   assign wr_flag = bus_wr && (bus_addr == ADDR_W'(ADR_FLAG));

   always_ff @(posedge clk) begin
      if (!rst_n)       edge_q <= '0;
      else if (wr_edge) edge_q <= bus_wdata[EDGE_W-1:0];
   end

   generate
      for (genvar c = 0; c < N_IC; c++) begin : g_chan
         edge_sel_e sel;
         assign sel = edge_sel_e'(edge_q[2*(N_IC-c)-1 -: 2]);

         tcap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ic_pin[c]),
            .sel  (sel),
            .hit  (ic_hit[c])
         );

         tcap_cap_reg #(.CNT_W(CNT_W)) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .load (ic_hit[c]),
            .cnt  (free_cnt),
            .q    (cap_q[c])
         );
      end
   endgenerate

   tcap_flag_bank #(.N_OC(N_OC), .N_IC(N_IC), .REG_W(REG_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask_wr(wr_mask),
      .flag_wr(wr_flag),
      .wdata  (bus_wdata),
      .oc_evt (oc_evt),
      .ic_hit (ic_hit),
      .flag_q (flag_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_EDGE)) bus_rdata = REG_W'(edge_q);
      if (bus_addr == ADDR_W'(ADR_MASK)) bus_rdata = mask_q;
      if (bus_addr == ADDR_W'(ADR_FLAG)) bus_rdata = flag_q;
      for (int c = 0; c < N_IC; c++) begin
         if (bus_addr == ADDR_W'(ADR_CAP0 + 2 * c))     bus_rdata = cap_q[c][CNT_W-1:REG_W];
         if (bus_addr == ADDR_W'(ADR_CAP0 + 2 * c + 1)) bus_rdata = cap_q[c][REG_W-1:0];
      end
   end

   AST_EDGE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ADR_EDGE)) |-> (bus_rdata[REG_W-1:EDGE_W] == '0)); // R2

endmodule

// File: tb/tb_tcap_unit.sv
module tb_tcap_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] free_cnt = '0;
   logic [2:0]  ic_pin = '0;
   logic [4:0]  oc_evt = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq;

   int nvec = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   tcap_unit dut (
      .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .ic_pin(ic_pin),
      .oc_evt(oc_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd_cap(input int c, output logic [15:0] v);
      logic [7:0] hi, lo;
      rd(4'(4 + 2 * c), hi);
      rd(4'(5 + 2 * c), lo);
      v = {hi, lo};
   endtask

   task automatic pin_event(input int c, input logic lvl, input logic [15:0] cnt);
      @(negedge clk);
      free_cnt = cnt;
      ic_pin[c] = lvl;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic sel_hit(input logic [1:0] code, input logic new_lvl);
      return new_lvl ? code[0] : code[1];
   endfunction

   function automatic logic [1:0] code_of(input logic [7:0] ctrl, input int c);
      return ctrl[2*(3-c)-1 -: 2];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] v;
      logic [7:0]  m_flag;
      logic [15:0] m_cap [3];
      logic [2:0]  m_lvl;

      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d); chk("R1 edge reset", d, 8'h00);
      rd(4'd1, d); chk("R1 mask reset", d, 8'h00);
      rd(4'd2, d); chk("R1 flag reset", d, 8'h00);
      for (int c = 0; c < 3; c++) begin
         rd_cap(c, v); chk("R1 capture reset", v, 16'h0000);
      end
      chk("R1 irq reset", irq, 1'b0);

      // R2 register layout
      wr(4'd0, 8'hFF); rd(4'd0, d); chk("R2 edge bits 7:6 read zero", d, 8'h3F);
      wr(4'd1, 8'hA5); rd(4'd1, d); chk("R2 mask readback", d, 8'hA5);
      wr(4'd1, 8'h00); wr(4'd0, 8'h00);

      // R3 disabled channel
      pin_event(0, 1'b1, 16'hBEEF);
      rd(4'd2, d); chk("R3 disabled no flag", d, 8'h00);
      rd_cap(0, v); chk("R3 disabled no capture", v, 16'h0000);
      pin_event(0, 1'b0, 16'hBEEF);

      // R4 rising only on channel 0 (bits 5:4 = 01)
      wr(4'd0, 8'h10);
      pin_event(0, 1'b1, 16'h1234);
      rd(4'd2, d); chk("R4 rising sets channel 0 flag", d, 8'h04);
      rd_cap(0, v); chk("R7 capture value", v, 16'h1234);
      wr(4'd2, 8'hFF);
      pin_event(0, 1'b0, 16'h5678);
      rd(4'd2, d); chk("R4 falling ignored", d, 8'h00);
      rd_cap(0, v); chk("R4 capture unchanged on falling", v, 16'h1234);

      // R5 falling only on channel 2 (bits 1:0 = 10)
      wr(4'd0, 8'h02);
      pin_event(2, 1'b1, 16'h0101);
      rd(4'd2, d); chk("R5 rising ignored", d, 8'h00);
      pin_event(2, 1'b0, 16'hA0A0);
      rd(4'd2, d); chk("R5 falling sets channel 2 flag", d, 8'h01);
      rd_cap(2, v); chk("R5 capture on falling", v, 16'hA0A0);
      wr(4'd2, 8'hFF);

      // R6 both edges on channel 1 (bits 3:2 = 11)
      wr(4'd0, 8'h0C);
      pin_event(1, 1'b1, 16'h0F0F);
      rd(4'd2, d); chk("R6 rising captured", d, 8'h02);
      wr(4'd2, 8'hFF);
      pin_event(1, 1'b0, 16'hF00D);
      rd(4'd2, d); chk("R6 falling captured", d, 8'h02);
      rd_cap(1, v); chk("R6 capture value", v, 16'hF00D);
      wr(4'd2, 8'hFF); wr(4'd0, 8'h00);

      // R8 / R9 output compare strobes with all masks clear
      @(negedge clk); oc_evt = 5'b10101;
      @(negedge clk); oc_evt = 5'b00000;
      rd(4'd2, d); chk("R8 R9 strobe layout with mask clear", d, 8'hA8);

      // R10 write-one-to-clear
      wr(4'd2, 8'h00); rd(4'd2, d); chk("R10 zero write keeps flags", d, 8'hA8);
      wr(4'd2, 8'h80); rd(4'd2, d); chk("R10 one write clears bit", d, 8'h28);

      // R11 set wins over clear
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h40; oc_evt = 5'b00010;
      @(negedge clk);
      bus_wr = 1'b0; oc_evt = 5'b00000;
      rd(4'd2, d); chk("R11 set beats clear", d, 8'h68);
      wr(4'd2, 8'h20); rd(4'd2, d); chk("R10 clear after collision", d, 8'h48);

      // R12 registered irq
      wr(4'd1, 8'h08);
      chk("R12 irq one cycle late", irq, 1'b0);
      @(negedge clk); chk("R12 irq asserted", irq, 1'b1);
      wr(4'd2, 8'h08);
      chk("R12 irq holds one cycle after clear", irq, 1'b1);
      @(negedge clk); chk("R12 irq drops", irq, 1'b0);
      wr(4'd2, 8'hFF); wr(4'd1, 8'h00);

      // random phase
      m_lvl = '0;
      for (int c = 0; c < 3; c++) rd_cap(c, m_cap[c]);
      m_flag = '0;
      for (int it = 0; it < 150; it++) begin
         logic [7:0]  ctrl, msk;
         logic [15:0] cnt;
         int          ch;
         logic        nl;
         ctrl = 8'($urandom) & 8'h3F;
         msk  = 8'($urandom);
         cnt  = 16'($urandom);
         ch   = int'($urandom % 3);
         nl   = ~m_lvl[ch];
         wr(4'd0, ctrl);
         wr(4'd1, msk);
         pin_event(ch, nl, cnt);
         m_lvl[ch] = nl;
         if (sel_hit(code_of(ctrl, ch), nl)) begin
            m_flag[2-ch] = 1'b1;
            m_cap[ch] = cnt;
         end
         rd(4'd2, d); chk("R4 R5 R6 random flag", d, m_flag);
         rd_cap(ch, v); chk("R7 random capture", v, m_cap[ch]);
         @(negedge clk);
         chk("R12 random irq", irq, |(m_flag & msk));
         wr(4'd2, 8'hFF);
         m_flag = '0;
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule